// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debugger reach system memory without halting a processor. Software drives it through a small register window. The window holds one control/status word, up to four address words and up to four data words. Some register accesses have side effects, and those side effects start single-beat bus transactions of 8 to 128 bits on a generic request/response port. Depending on the mode bits, a bus read starts when address word 0 is written or when data word 0 is read. A bus write always starts when data word 0 is written. An optional post-increment steps the address by the access width, so repeated data accesses walk through consecutive locations.

Faults are kept as sticky status. A 3-bit error code records a bus error response, a misaligned address or an unsupported width. A separate flag records an access that arrived while a transaction was still in flight. Both are cleared by writing ones to them. While either one is set, no new transaction starts.

Register indices: 0 is the control/status word, 1 to 4 are address words 0 to 3 (word 0 holds the least significant bits), and 5 to 8 are data words 0 to 3. Control/status layout: [2:0] width code, [3] post-increment, [4] read when address word 0 is written, [5] read when data word 0 is read, [8:6] error code, [9] busy-clash flag, [10] busy, [15:11] width capability for 8/16/32/64/128 bits, [18:16] version. All other bits read as zero.

Top module: `sba_engine`

## Requirements
- R1: After reset the control/status word reads version 1 in [18:16]. Bit 11+i is set exactly when an access of 8·2^i bits fits in DATA_W. Every writable field and every status bit reads zero (0x0001_7800 for DATA_W=64).
- R2: Writing data word 0 while idle and error-free issues one bus write, with bus_req raised in the next cycle. The write goes to the current address, with width code = the control width field, and carries the data words as bus_wdata (word k on bits 32k+31:32k).
- R3: With read-on-address set, writing address word 0 issues a bus read at the new address. The returned data fills data words 0 up to the access width. For 8- and 16-bit reads, data word 0 holds the value zero-extended in its low bits.
- R4: With read-on-data set, reading data word 0 returns its present value and, in the same access, starts the next bus read.
- R5: With post-increment set, every access that completes without error advances the address by 2^width bytes.
- R6: A bus error response on a read or a write sets the error code to 2. It leaves the address and the data words unchanged.
- R7: An address that is not a multiple of 2^width bytes sets the error code to 3, and no request is issued.
- R8: A width code above log2(DATA_W/8) sets the error code to 4, and no request is issued.
- R9: Writing the control word clears each error-code bit and the busy-clash flag (bit 9) where the written bit is 1. Other error bits are left as they are.
- R10: A write to any address or data word, or a read of data word 0, while busy sets the sticky busy-clash flag. The register is left unchanged.
- R11: The busy bit and bus_req are high from the cycle after a trigger until the edge that accepts bus_rsp_valid. Address, direction and width stay stable while the request waits.
- R12: While the error code is non-zero or the busy-clash flag is set, no trigger starts a bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effects only) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| bus_req | output | 1 | Transaction request, held until response |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_size | output | 3 | Width code, 2^code bytes |
| bus_wdata | output | DATA_W | Write data |
| bus_rsp_valid | input | 1 | Response for the pending request |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rdata | input | DATA_W | Read data, valid with the response |

## Verification
The hardest situation to reach is a register access that lands while a transaction is still in flight. With a fast responder the window is only a cycle or two wide. The bench therefore stretches its memory responder's latency to six cycles before it pokes the address and data words and reads the status. It then confirms that the flag is sticky, that the poked register kept its value, and that triggers stay dead until the flag is cleared. The read-on-data streaming path is also exercised, because the value returned always belongs to the previous transaction.

// File: rtl/sba_engine.sv
module sba_engine #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int NAW   = ADDR_W / 32;
  localparam int NDW   = DATA_W / 32;
  localparam int MAXSZ = $clog2(DATA_W / 8);
  localparam logic [3:0] IX_CTRL = 4'd0;
  localparam logic [3:0] IX_A0   = 4'd1;
  localparam logic [3:0] IX_D0   = 4'd5;

  logic [2:0]        size_q, xsz_q, err_q;
  logic              inc_q, roa_q, rod_q, berr_q, busy_q, we_q;
  logic [ADDR_W-1:0] addr_q, tgt_addr, step;
  logic [31:0]       data_q [NDW];
  logic [31:0]       low_word;
  logic [4:0]        caps, amask;
  logic              is_a, is_d, touch, clash, idle_ok, go_wr, go_rd, go;
  logic              bad_size, misal, rsp;

  for (genvar i = 0; i < 5; i++) begin : g_cap
    assign caps[i] = ((8 << i) <= DATA_W);
  end

  assign is_a     = reg_addr >= 4'd1 && reg_addr <= 4'd4;
  assign is_d     = reg_addr >= 4'd5 && reg_addr <= 4'd8;
  assign touch    = (reg_we && (is_a || is_d)) || (reg_re && reg_addr == IX_D0);
  assign clash    = touch && busy_q;
  assign idle_ok  = !busy_q && err_q == 3'd0 && !berr_q;
  assign go_wr    = idle_ok && reg_we && reg_addr == IX_D0;
  assign go_rd    = idle_ok && ((reg_we && reg_addr == IX_A0 && roa_q) ||
                                (reg_re && reg_addr == IX_D0 && rod_q));
  assign go       = go_wr || go_rd;
  assign amask    = (5'd1 << size_q) - 5'd1;
  assign bad_size = int'(size_q) > MAXSZ;
  assign misal    = |(tgt_addr[3:0] & amask[3:0]);
  assign rsp      = busy_q && bus_rsp_valid;
  assign step     = ADDR_W'(1) << xsz_q;

  always_comb begin
    tgt_addr = addr_q;
    if (reg_we && reg_addr == IX_A0) tgt_addr[31:0] = reg_wdata;
  end

  always_comb begin
    case (xsz_q)
      3'd0:    low_word = {24'd0, bus_rdata[7:0]};
      3'd1:    low_word = {16'd0, bus_rdata[15:0]};
      default: low_word = bus_rdata[31:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0; xsz_q <= '0; err_q <= '0;
      inc_q <= 1'b0; roa_q <= 1'b0; rod_q <= 1'b0;
      berr_q <= 1'b0; busy_q <= 1'b0; we_q <= 1'b0;
      addr_q <= '0;
      for (int k = 0; k < NDW; k++) data_q[k] <= '0;
    end else begin
      if (clash) begin
        berr_q <= 1'b1;
      end else if (reg_we) begin
        if (reg_addr == IX_CTRL) begin
          size_q <= reg_wdata[2:0];
          inc_q  <= reg_wdata[3];
          roa_q  <= reg_wdata[4];
          rod_q  <= reg_wdata[5];
          err_q  <= err_q & ~reg_wdata[8:6];
          berr_q <= berr_q & ~reg_wdata[9];
        end
        for (int k = 0; k < NAW; k++)
          if (reg_addr == 4'(1 + k)) addr_q[32*k +: 32] <= reg_wdata;
        for (int k = 0; k < NDW; k++)
          if (reg_addr == 4'(5 + k)) data_q[k] <= reg_wdata;
      end
      if (go) begin
        if (bad_size)   err_q <= 3'd4;
        else if (misal) err_q <= 3'd3;
        else begin
          busy_q <= 1'b1;
          we_q   <= go_wr;
          xsz_q  <= size_q;
        end
      end
      if (rsp) begin
        busy_q <= 1'b0;
        if (bus_rsp_err) begin
          err_q <= 3'd2;
        end else begin
          if (inc_q) addr_q <= addr_q + step;
          if (!we_q) begin
            data_q[0] <= low_word;
            for (int k = 1; k < NDW; k++)
              if (32 * k < (8 << xsz_q)) data_q[k] <= bus_rdata[32*k +: 32];
          end
        end
      end
    end
  end

  assign bus_req  = busy_q;
  assign bus_we   = we_q;
  assign bus_addr = addr_q;
  assign bus_size = xsz_q;
  for (genvar k = 0; k < NDW; k++) begin : g_wd
    assign bus_wdata[32*k +: 32] = data_q[k];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == IX_CTRL)
      reg_rdata = {13'd0, 3'd1, caps, busy_q, berr_q, err_q, rod_q, roa_q, inc_q, size_q};
    for (int k = 0; k < NAW; k++)
      if (reg_addr == 4'(1 + k)) reg_rdata = addr_q[32*k +: 32];
    for (int k = 0; k < NDW; k++)
      if (reg_addr == 4'(5 + k)) reg_rdata = data_q[k];
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rsp_valid |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)); // R11
  AST_BUSERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rsp_valid && bus_rsp_err |=> err_q == 3'd2); // R6
  AST_AUTOINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_rsp_valid && !bus_rsp_err && inc_q |=> bus_addr == $past(bus_addr) + (ADDR_W'(1) << $past(bus_size))); // R5
  AST_BERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    berr_q && !(reg_we && reg_addr == IX_CTRL && reg_wdata[9]) |=> berr_q); // R10
  AST_QUIET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && (err_q != 3'd0 || berr_q) |=> !bus_req); // R12
  AST_NO_REQ_BADSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && bad_size && !(reg_we && reg_addr == IX_CTRL) |=> !bus_req); // R8
endmodule

// File: tb/sba_engine_tb_top.sv
module sba_engine_tb_top;
  localparam int AW = 64;
  localparam int DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [2:0] bus_size;
  logic [DW-1:0] bus_wdata;
  logic bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  sba_engine #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .bus_rdata(bus_rdata));

  typedef struct { logic [63:0] a; logic w; } req_t;
  req_t exp_q[$];
  logic [7:0] mem [logic [63:0]];
  int n_chk = 0, n_fail = 0, lat = 1, wait_cnt = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Reference model: queue of expected transactions plus a byte memory responder.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 request level", {63'd0, bus_req}, {63'd0, exp_q.size() > 0});
      if (bus_req && exp_q.size() > 0) begin
        chk("R2 R3 bus address", bus_addr, exp_q[0].a);
        chk("R2 R3 bus direction", {63'd0, bus_we}, {63'd0, exp_q[0].w});
      end
      if (bus_rsp_valid) begin
        bus_rsp_valid = 1'b0;
        bus_rsp_err = 1'b0;
      end else if (bus_req) begin
        wait_cnt++;
        if (wait_cnt >= lat) begin
          wait_cnt = 0;
          bus_rsp_valid = 1'b1;
          bus_rsp_err = bus_addr >= 64'h8000;
          bus_rdata = '0;
          for (int b = 0; b < (1 << bus_size); b++) begin
            if (bus_we && !bus_rsp_err) mem[bus_addr + 64'(b)] = bus_wdata[8*b +: 8];
            else if (mem.exists(bus_addr + 64'(b))) bus_rdata[8*b +: 8] = mem[bus_addr + 64'(b)];
          end
          if (exp_q.size() > 0) void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input bit go = 0,
                    input logic [63:0] ea = 0, input bit ew = 0);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (go) exp_q.push_back('{ea, ew});
  endtask

  task automatic rd(input int a, output logic [31:0] d, input bit go = 0,
                    input logic [63:0] ea = 0);
    @(negedge clk);
    reg_addr = 4'(a); reg_re = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 1'b0;
    if (go) exp_q.push_back('{ea, 1'b0});
  endtask

  task automatic settle();
    while (exp_q.size() > 0 || bus_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    rd(0, v); chk("R1 reset control word", 64'(v), 64'h0001_7800);

    wr(0, 2); wr(2, 0); wr(1, 'h100);
    wr(5, 'hdeadbeef, 1, 'h100, 1); settle();
    wr(0, 2 | 16); wr(1, 'h100, 1, 'h100, 0); settle();
    rd(5, v); chk("R3 word read back", 64'(v), 64'hdeadbeef);

    wr(0, 0); wr(1, 'h101); wr(5, 'h1234_5655, 1, 'h101, 1); settle();
    wr(0, 16); wr(1, 'h101, 1, 'h101, 0); settle();
    rd(5, v); chk("R3 byte read zero-extended", 64'(v), 64'h55);
    wr(0, 2 | 16); wr(1, 'h100, 1, 'h100, 0); settle();
    rd(5, v); chk("R2 byte write lane", 64'(v), 64'hdead55ef);

    wr(0, 1); wr(1, 'h103); wr(5, 1); settle();
    rd(0, v); chk("R7 misaligned code", 64'(v[8:6]), 64'd3);
    wr(5, 2); settle();
    rd(0, v); chk("R12 no trigger while error", 64'(v[10]), 64'd0);
    wr(0, 1 | (1 << 6)); rd(0, v); chk("R9 partial clear keeps bit", 64'(v[8:6]), 64'd2);
    wr(0, 1 | (2 << 6)); rd(0, v); chk("R9 error cleared", 64'(v[8:6]), 64'd0);

    wr(0, 4); wr(5, 0); settle();
    rd(0, v); chk("R8 unsupported width code", 64'(v[8:6]), 64'd4);
    wr(0, 7 << 6); rd(0, v); chk("R9 clear width error", 64'(v[8:6]), 64'd0);

    wr(0, 3); wr(1, 'h200); wr(6, 'hcafef00d);
    wr(5, 'h01234567, 1, 'h200, 1); settle();
    wr(0, 3 | 16); wr(1, 'h200, 1, 'h200, 0); settle();
    rd(5, v); chk("R3 64-bit low word", 64'(v), 64'h01234567);
    rd(6, v); chk("R3 64-bit high word", 64'(v), 64'hcafef00d);

    wr(0, 2 | 8); wr(1, 'h300);
    for (int i = 0; i < 3; i++) begin
      wr(5, 10 + i, 1, 64'h300 + 64'(4 * i), 1); settle();
    end
    rd(1, v); chk("R5 word increment", 64'(v), 64'h30c);
    wr(0, 8); wr(1, 'h400);
    wr(5, 7, 1, 'h400, 1); settle();
    wr(5, 8, 1, 'h401, 1); settle();
    rd(1, v); chk("R5 byte increment", 64'(v), 64'h402);

    wr(0, 2 | 8 | 32); wr(1, 'h300);
    rd(5, v, 1, 'h300); settle();
    for (int i = 0; i < 3; i++) begin
      rd(5, v, 1, 64'h304 + 64'(4 * i));
      chk("R4 streamed value", 64'(v), 64'(10 + i));
      settle();
    end

    wr(0, 2 | 8); wr(1, 'h8000);
    wr(5, 1, 1, 'h8000, 1); settle();
    rd(0, v); chk("R6 write error code", 64'(v[8:6]), 64'd2);
    rd(1, v); chk("R6 address held", 64'(v), 64'h8000);
    wr(0, 2 | 16 | (7 << 6)); wr(1, 'h8004, 1, 'h8004, 0); settle();
    rd(0, v); chk("R6 read error code", 64'(v[8:6]), 64'd2);
    rd(5, v); chk("R6 data held", 64'(v), 64'd1);
    wr(0, 2 | (7 << 6));

    lat = 6;
    wr(1, 'h100); wr(5, 'h11, 1, 'h100, 1);
    wr(1, 'h500);
    rd(0, v);
    chk("R11 busy bit", 64'(v[10]), 64'd1);
    chk("R10 clash flag", 64'(v[9]), 64'd1);
    settle();
    rd(1, v); chk("R10 address unchanged", 64'(v), 64'h100);
    wr(5, 'h22); settle();
    rd(0, v); chk("R12 flag sticky, idle", 64'({v[10], v[9]}), 64'd1);
    wr(0, 2 | (1 << 9)); rd(0, v); chk("R9 clash flag cleared", 64'(v[9]), 64'd0);
    lat = 1;
    wr(0, 2 | 16); wr(1, 'h100, 1, 'h100, 0); settle();
    rd(5, v); chk("R2 write after clash", 64'(v), 64'h11);

    finish_run();
  end
endmodule